// File: doc/BRIEF.md
# Unlock command sequence decoder

This block sits beside the load path of a byte-wide non-volatile memory. It watches every byte-load cycle, which is one address and data pair marked by `ld_valid`. It picks out the short unlock sequences that control the memory. Command addresses are compared on the low 15 address bits only, so the two upper address bits never change which command is seen. The lead-in pair is address 0x5555 with data 0xAA, then address 0x2AAA with data 0x55. After the lead-in, a third cycle at 0x5555 gives one of three results:
- 0xA0 turns write protection on and permits the next load.
- 0xF0 leaves identification mode.
- 0x80 opens a longer form: the lead-in again, then a final cycle at 0x5555. The final data is 0x20 to drop protection, 0x10 to request an erase of the whole array, or 0x60 to enter identification mode.

While protection is on, a load that is not preceded by the 0xA0 form is refused and starts a lockout. The lockout lasts `LOCK_CYCLES` clock cycles, and every load during it is ignored. In identification mode a read address whose bits 14..1 are all zero selects a fixed code byte. Bit 0 low selects the manufacturer code, and bit 0 high selects the device code.

The sequence matcher holds seven states:
- `ST_IDLE` has nothing pending.
- `ST_PRE1` has seen the first lead-in cycle.
- `ST_PRE2` has seen the full lead-in.
- `ST_EXT1`, `ST_EXT2` and `ST_EXT3` are the long form after 0x80, the repeated lead-in bytes.
- `ST_ARMED` follows 0xA0 and passes exactly one data load.

The transitions are:
- The expected next pair advances the state.
- Any other cycle is a break: it returns to `ST_IDLE` and counts as a data load. That load is permitted when unprotected and starts a lockout when protected.
- The final cycle of a sequence returns to `ST_IDLE`.
- The one load taken in `ST_ARMED` returns to `ST_IDLE`.
- A refused load sends the matcher to `ST_IDLE` as the lockout starts.

Top module: `unlock_seq_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, protection is off, identification mode is off, lockout is low, and both strobes are low.
- R2: With protection off, a load that is not part of a sequence raises `wr_permit` for exactly one cycle, in the cycle after the load.
- R3: The cycles 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 set `prot_on` in the cycle after the third load. The very next load then raises `wr_permit` even though protection is on.
- R4: With protection on, a load that was not armed by R3 raises no `wr_permit`. It raises `lockout` for exactly `LOCK_CYCLES` cycles, starting the cycle after the load.
- R5: While `lockout` is high, every load is ignored. No strobe rises, and a full arming sequence given during lockout does not arm the next load.
- R6: The six cycles 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20 clear `prot_on`.
- R7: The same six-cycle form ending in data 0x10 raises `erase_req` for one cycle, in the cycle after the last load.
- R8: The six-cycle form ending in 0x60 sets `id_mode`. The three cycles 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xF0 clear it.
- R9: In identification mode, a read address with bits 14..1 zero gives `id_hit` high. `id_data` is then 0xBF when bit 0 is 0 and 0x07 when bit 0 is 1, whatever bits 16..15 hold. At any other address, or outside identification mode, `id_hit` is low and `id_data` is 0x00.
- R10: A cycle that breaks a partly matched sequence returns the matcher to idle. With protection off, that cycle raises `wr_permit`.
- R11: Address bits 16..15 of a load are ignored when matching commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A byte-load cycle is presented this clock |
| ld_addr | input | 17 | Byte-load address |
| ld_data | input | 8 | Byte-load data |
| rd_addr | input | 17 | Read address for the identification code mux |
| prot_on | output | 1 | Software write protection is enabled |
| wr_permit | output | 1 | One-cycle strobe: the preceding load may enter the page buffer |
| erase_req | output | 1 | One-cycle strobe: erase the whole array to all ones |
| id_mode | output | 1 | Identification mode is active |
| lockout | output | 1 | A refused write has frozen load handling |
| id_hit | output | 1 | The read address selects a code byte |
| id_data | output | 8 | Code byte for the read address |

## Verification
The bench builds the block with `LOCK_CYCLES` set to 8, in place of the default of 40000 cycles. This short lockout lets the bench count the lockout window exactly, cycle by cycle. It also leaves room to issue a complete arming sequence inside the window and then confirm, after expiry, that the sequence had no effect. The address and code parameters keep their defaults, so the vectors use the real command addresses, including aliases with bits 16..15 set.

// File: rtl/usd_pkg.sv
package usd_pkg;

    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] ADR_LEAD   = 15'h5555;
    localparam logic [CMD_AW-1:0] ADR_SECOND = 15'h2AAA;

    localparam logic [7:0] D_LEAD   = 8'hAA;
    localparam logic [7:0] D_SECOND = 8'h55;
    localparam logic [7:0] D_PROT   = 8'hA0;
    localparam logic [7:0] D_EXT    = 8'h80;
    localparam logic [7:0] D_EXIT   = 8'hF0;
    localparam logic [7:0] D_UNPROT = 8'h20;
    localparam logic [7:0] D_ERASE  = 8'h10;
    localparam logic [7:0] D_IDENT  = 8'h60;

    typedef enum logic [3:0] {
        TK_NONE,
        TK_LEAD,
        TK_SECOND,
        TK_PROT,
        TK_EXT,
        TK_EXIT,
        TK_UNPROT,
        TK_ERASE,
        TK_IDENT,
        TK_OTHER
    } tok_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE1,
        ST_PRE2,
        ST_EXT1,
        ST_EXT2,
        ST_EXT3,
        ST_ARMED
    } st_t;

endpackage

// File: rtl/usd_tok_match.sv
module usd_tok_match
    import usd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output tok_t              tok
);

    localparam int HI_W = ADDR_W - CMD_AW;

    logic [CMD_AW-1:0] low_addr;
    logic [HI_W-1:0]   unused_hi;
    logic              at_lead;
    logic              at_second;

    assign low_addr  = addr[CMD_AW-1:0];
    assign unused_hi = addr[ADDR_W-1:CMD_AW];
    assign at_lead   = (low_addr == ADR_LEAD);
    assign at_second = (low_addr == ADR_SECOND);

    always_comb begin
        tok = TK_OTHER;
        if (!valid) begin
            tok = TK_NONE;
        end else if (at_second) begin
            if (data == D_SECOND) tok = TK_SECOND;
        end else if (at_lead) begin
            unique case (data)
                D_LEAD:   tok = TK_LEAD;
                D_PROT:   tok = TK_PROT;
                D_EXT:    tok = TK_EXT;
                D_EXIT:   tok = TK_EXIT;
                D_UNPROT: tok = TK_UNPROT;
                D_ERASE:  tok = TK_ERASE;
                D_IDENT:  tok = TK_IDENT;
                default:  tok = TK_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/usd_cmd_fsm.sv
module usd_cmd_fsm
    import usd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  tok_t tok,
    input  logic locked,
    output logic lock_go,
    output logic prot_on,
    output logic id_mode,
    output logic wr_permit,
    output logic erase_req
);

    st_t  st;
    st_t  st_nxt;
    logic act_wr;
    logic act_er;
    logic set_prot;
    logic clr_prot;
    logic set_id;
    logic clr_id;
    logic brk;
    logic live;

    assign live = (tok != TK_NONE) && !locked;

    always_comb begin
        st_nxt   = st;
        act_wr   = 1'b0;
        act_er   = 1'b0;
        set_prot = 1'b0;
        clr_prot = 1'b0;
        set_id   = 1'b0;
        clr_id   = 1'b0;
        brk      = 1'b0;
        lock_go  = 1'b0;
        if (live) begin
            unique case (st)
                ST_IDLE: begin
                    if (tok == TK_LEAD) st_nxt = ST_PRE1;
                    else                brk    = 1'b1;
                end
                ST_PRE1: begin
                    if (tok == TK_SECOND) st_nxt = ST_PRE2;
                    else                  brk    = 1'b1;
                end
                ST_PRE2: begin
                    if (tok == TK_PROT) begin
                        set_prot = 1'b1;
                        st_nxt   = ST_ARMED;
                    end else if (tok == TK_EXT) begin
                        st_nxt = ST_EXT1;
                    end else if (tok == TK_EXIT) begin
                        clr_id = 1'b1;
                        st_nxt = ST_IDLE;
                    end else begin
                        brk = 1'b1;
                    end
                end
                ST_EXT1: begin
                    if (tok == TK_LEAD) st_nxt = ST_EXT2;
                    else                brk    = 1'b1;
                end
                ST_EXT2: begin
                    if (tok == TK_SECOND) st_nxt = ST_EXT3;
                    else                  brk    = 1'b1;
                end
                ST_EXT3: begin
                    if (tok == TK_UNPROT) begin
                        clr_prot = 1'b1;
                        st_nxt   = ST_IDLE;
                    end else if (tok == TK_ERASE) begin
                        act_er = 1'b1;
                        st_nxt = ST_IDLE;
                    end else if (tok == TK_IDENT) begin
                        set_id = 1'b1;
                        st_nxt = ST_IDLE;
                    end else begin
                        brk = 1'b1;
                    end
                end
                ST_ARMED: begin
                    act_wr = 1'b1;
                    st_nxt = ST_IDLE;
                end
                default: begin
                    st_nxt = ST_IDLE;
                end
            endcase
            if (brk) begin
                st_nxt = ST_IDLE;
                if (prot_on) lock_go = 1'b1;
                else         act_wr  = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // output and mode flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_on   <= 1'b0;
            id_mode   <= 1'b0;
            wr_permit <= 1'b0;
            erase_req <= 1'b0;
        end else begin
            wr_permit <= act_wr;
            erase_req <= act_er;
            if (set_prot)      prot_on <= 1'b1;
            else if (clr_prot) prot_on <= 1'b0;
            if (set_id)        id_mode <= 1'b1;
            else if (clr_id)   id_mode <= 1'b0;
        end
    end

endmodule

// File: rtl/usd_lock_timer.sv
module usd_lock_timer #(
    parameter int LOCK_CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic locked
);

    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(LOCK_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= LOAD_VAL;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign locked = (cnt != '0);

endmodule

// File: rtl/usd_id_mux.sv
module usd_id_mux
    import usd_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter logic [7:0] MFR_CODE = 8'hBF,
    parameter logic [7:0] DEV_CODE = 8'h07
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              id_hit,
    output logic [7:0]        id_data
);

    localparam int HI_W = ADDR_W - CMD_AW;

    logic [HI_W-1:0] unused_hi;

    assign unused_hi = rd_addr[ADDR_W-1:CMD_AW];
    assign id_hit    = id_mode && (rd_addr[CMD_AW-1:1] == '0);
    assign id_data   = !id_hit     ? 8'h00 :
                       rd_addr[0]  ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import usd_pkg::*;
#(
    parameter int         ADDR_W      = 17,
    parameter int         LOCK_CYCLES = 40000,
    parameter logic [7:0] MFR_CODE    = 8'hBF,
    parameter logic [7:0] DEV_CODE    = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prot_on,
    output logic              wr_permit,
    output logic              erase_req,
    output logic              id_mode,
    output logic              lockout,
    output logic              id_hit,
    output logic [7:0]        id_data
);

    tok_t tok;
    logic lock_go;

    usd_tok_match #(.ADDR_W(ADDR_W), .DATA_W(8)) u_match (
        .valid (ld_valid),
        .addr  (ld_addr),
        .data  (ld_data),
        .tok   (tok)
    );

    usd_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok       (tok),
        .locked    (lockout),
        .lock_go   (lock_go),
        .prot_on   (prot_on),
        .id_mode   (id_mode),
        .wr_permit (wr_permit),
        .erase_req (erase_req)
    );

    usd_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (lock_go),
        .locked (lockout)
    );

    usd_id_mux #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_idm (
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .id_hit  (id_hit),
        .id_data (id_data)
    );

endmodule

// File: rtl/usd_checker.sv
module usd_checker (
    input logic clk,
    input logic rst_n,
    input logic ld_valid,
    input logic prot_on,
    input logic wr_permit,
    input logic erase_req,
    input logic id_mode,
    input logic lockout,
    input logic id_hit
);

    // R1: quiet state held during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!prot_on && !id_mode && !lockout && !wr_permit && !erase_req)
                else $error("R1 outputs not cleared in reset");
        end
    end

    // R2: a permit strobe always follows a load
    p_wr_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> $past(ld_valid));

    // R4: lockout only starts from a load made while protected
    p_lock_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockout) |-> ($past(ld_valid) && $past(prot_on)));

    // R5: loads during lockout produce no strobe
    p_lock_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout && ld_valid) |=> (!wr_permit && !erase_req));

    // R7: erase strobe needs an accepted load
    p_erase_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> ($past(ld_valid) && !$past(lockout)));

    // R9: code bytes only appear in identification mode
    p_hit_needs_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        id_hit |-> id_mode);

    // R10: a single load yields at most one kind of strobe
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_permit, erase_req}) <= 1);

endmodule

bind unlock_seq_decoder usd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .prot_on   (prot_on),
    .wr_permit (wr_permit),
    .erase_req (erase_req),
    .id_mode   (id_mode),
    .lockout   (lockout),
    .id_hit    (id_hit)
);

// File: tb/tb_unlock_seq_decoder.sv
`timescale 1ns/1ps
module tb_unlock_seq_decoder;

    localparam int AW   = 17;
    localparam int LOCK = 8;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic          wr;
        logic          er;
        logic          pr;
        logic          id;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t TBL [0:NV-1] = '{
        '{17'h00123, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 plain load
        '{17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'hA0, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 protect
        '{17'h00040, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 armed load
        '{17'h15555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b0},  // R11 alias
        '{17'h0AAAA, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0},  // R11 alias
        '{17'h05555, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
        '{17'h05555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b0},
        '{17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0},
        '{17'h05555, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 unprotect
        '{17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'h10, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 erase
        '{17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'h60, 1'b0, 1'b0, 1'b0, 1'b1},  // R8 enter ID
        '{17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b1},
        '{17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1},
        '{17'h05555, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 exit ID
        '{17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h01234, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0},  // R10 break after lead
        '{17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0},
        '{17'h05555, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b0}   // R10 break at third
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          prot_on, wr_permit, erase_req, id_mode, lockout, id_hit;
    logic [7:0]    id_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    unlock_seq_decoder #(.ADDR_W(AW), .LOCK_CYCLES(LOCK)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .rd_addr   (rd_addr),
        .prot_on   (prot_on),
        .wr_permit (wr_permit),
        .erase_req (erase_req),
        .id_mode   (id_mode),
        .lockout   (lockout),
        .id_hit    (id_hit),
        .id_data   (id_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr  = a;
        ld_data  = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic wait_unlock();
        for (int i = 0; i < 100 && lockout; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 prot_on in reset", 32'(prot_on), 0);
        check("R1 id_mode in reset", 32'(id_mode), 0);
        check("R1 lockout in reset", 32'(lockout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wr_permit after reset", 32'(wr_permit), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            load(TBL[i].a, TBL[i].d);
            check($sformatf("R2/R3/R6/R7/R8/R10 wr_permit v%0d", i), 32'(wr_permit), 32'(TBL[i].wr));
            check($sformatf("R7 erase_req v%0d", i), 32'(erase_req), 32'(TBL[i].er));
            check($sformatf("R3/R6 prot_on v%0d", i), 32'(prot_on), 32'(TBL[i].pr));
            check($sformatf("R8 id_mode v%0d", i), 32'(id_mode), 32'(TBL[i].id));
        end
        @(negedge clk);
        check("R2 strobe lasts one cycle", 32'(wr_permit), 0);

        // R4: protected write without arming
        load(17'h05555, 8'hAA);
        load(17'h02AAA, 8'h55);
        load(17'h05555, 8'hA0);
        load(17'h00300, 8'h33);
        check("R3 armed load permitted", 32'(wr_permit), 1);
        load(17'h00301, 8'h34);
        check("R4 unarmed load refused", 32'(wr_permit), 0);
        n = 0;
        while (lockout && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R4 lockout length", 32'(n), 32'(LOCK));
        check("R4 protection kept", 32'(prot_on), 1);

        // R5: arming during lockout has no effect
        load(17'h00302, 8'h35);
        check("R5 lockout raised", 32'(lockout), 1);
        load(17'h05555, 8'hAA);
        check("R5 no strobe in lockout", 32'(wr_permit), 0);
        load(17'h02AAA, 8'h55);
        load(17'h05555, 8'hA0);
        wait_unlock();
        load(17'h00303, 8'h36);
        check("R5 sequence in lockout did not arm", 32'(wr_permit), 0);
        check("R5 new lockout after unarmed load", 32'(lockout), 1);
        wait_unlock();

        // R6 again from protected, then R9 ID reads
        load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55); load(17'h05555, 8'h80);
        load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55); load(17'h05555, 8'h20);
        check("R6 protection cleared", 32'(prot_on), 0);
        rd_addr = 17'h00000;
        #0.1;
        check("R9 no hit outside ID mode", 32'(id_hit), 0);
        check("R9 zero data outside ID mode", 32'(id_data), 0);
        load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55); load(17'h05555, 8'h80);
        load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55); load(17'h05555, 8'h60);
        rd_addr = 17'h00000; #0.1;
        check("R9 manufacturer code", 32'(id_data), 32'h00BF);
        check("R9 hit at 0", 32'(id_hit), 1);
        rd_addr = 17'h00001; #0.1;
        check("R9 device code", 32'(id_data), 32'h0007);
        rd_addr = 17'h18001; #0.1;
        check("R9 upper bits ignored", 32'(id_data), 32'h0007);
        rd_addr = 17'h00002; #0.1;
        check("R9 no hit off code address", 32'(id_hit), 0);
        check("R9 zero data off code address", 32'(id_data), 0);

        // R1: reset clears modes mid-operation
        load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55); load(17'h05555, 8'hA0);
        check("R3 protect with ID mode on", 32'(prot_on), 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears protection", 32'(prot_on), 0);
        check("R1 reset clears ID mode", 32'(id_mode), 0);
        rst_n = 1'b1;
        load(17'h00010, 8'h01);
        check("R1 armed state dropped by reset, plain load permitted", 32'(wr_permit), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule